// File: doc/BRIEF.md
# Per-Channel Baseline Follower

This block removes a slowly drifting baseline from a stream of detector samples that arrive one channel at a time, each with its channel index. For every channel it holds an accumulator that stands for 2^SHIFT past events. The baseline in use is that accumulator shifted right by SHIFT bits. Each incoming sample has its channel's baseline taken away, and the result leaves as a signed, saturated value two clock cycles later.

In follower mode each sample also folds back into its channel's accumulator. The accumulator loses one baseline's worth and gains the new sample, so it tracks the mean over roughly 2^SHIFT events. In download mode the accumulators stay fixed. A loader port sets one channel's baseline directly, in either mode. A separate update enable stops all accumulator changes while subtraction goes on, which is useful during calibration events.

Each read-modify-write of an accumulator takes two pipeline stages. A sample for a channel whose update is still in flight, or whose baseline is being loaded in the same cycle, gets the fresh value through forwarding. Input never has to pause.

Top module: `pedestal_follower`

## Requirements
- R1: After reset `outValid` is low, `outData` is zero, and every channel's accumulator is zero, so a sample leaves unchanged until its channel learns a baseline.
- R2: A sample accepted with `inValid` high in cycle t leaves with `outValid` high and `outChan` equal to its channel in cycle t+2. A cycle with `inValid` low yields `outValid` low two cycles later and leaves `outData` unchanged.
- R3: The baseline of a channel is its accumulator shifted right by SHIFT bits (accumulator bits SUM_W-1 down to SHIFT). The output is the sample minus that baseline, with both taken as unsigned numbers.
- R4: When OUT_W is narrower than SAMPLE_W+1, a difference above 2^(OW-1)-1 leaves as 2^(OW-1)-1, and a difference below -2^(OW-1) leaves as -2^(OW-1), where OW stands for OUT_W.
- R5: With `followMode` high and `updateEn` high, the accumulator of the sample's channel becomes accumulator - baseline + sample.
- R6: With `updateEn` low, no accumulator changes, but subtraction still takes place.
- R7: With `followMode` low (download mode), no accumulator changes.
- R8: A cycle with `hostWrEn` high sets the accumulator of `hostChan` to `hostPed` shifted left by SHIFT, so that channel's baseline becomes `hostPed`. This works in either mode.
- R9: Samples for the same channel in consecutive cycles each see the accumulator as left by the one before.
- R10: A sample that arrives in the same cycle as a load of its own channel uses the loaded baseline. A load wins over a pending follower update to the same channel.
- R11: Each channel's accumulator changes only through samples or loads for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample present this cycle |
| inChan | input | CH_W | Channel index of the sample |
| inSample | input | SAMPLE_W | Unsigned raw sample |
| followMode | input | 1 | 1: follower mode, 0: download mode |
| updateEn | input | 1 | 0 freezes accumulator updates |
| hostWrEn | input | 1 | Load a baseline this cycle |
| hostChan | input | CH_W | Channel index to load |
| hostPed | input | SAMPLE_W | Baseline value to load |
| outValid | output | 1 | Corrected sample present |
| outChan | output | CH_W | Channel index of the corrected sample |
| outData | output | OUT_W | Signed, saturated corrected sample |

## Verification
The assertions assume that `inChan` and `hostChan` always name an existing channel. They also assume that the accumulators only ever hold values reached through the update and load rules, so the baseline never exceeds the largest sample value. The bench keeps to a channel count that is a power of two, so every index is legal. It changes the accumulators only through samples and loads, and it computes the expected output by running the same accumulator arithmetic on a model of its own. Its phases cover an exhaustive baseline-by-sample sweep, runs of one repeated channel, random channel order with gaps, and loads that collide with samples.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Strobes passed from the control path to the datapath each cycle
  typedef struct packed {
    logic capture;   // register the incoming sample and its accumulator
    logic selHost;   // forward the value being loaded this cycle
    logic selWb;     // forward the update being written back this cycle
    logic wbWrite;   // write the updated accumulator of stage 1
    logic hostWrite; // write a loaded baseline
    logic outLoad;   // register a corrected output
  } pf_strobe_t;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int CH_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [CH_W-1:0] inChan,
  input  logic            followMode,
  input  logic            updateEn,
  input  logic            hostWrEn,
  input  logic [CH_W-1:0] hostChan,
  output pf_strobe_t      strb,
  output logic [CH_W-1:0] wbChan,
  output logic            outValid,
  output logic [CH_W-1:0] outChan
);
  logic            s1Valid;
  logic            s1Update;
  logic [CH_W-1:0] s1Chan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Update <= 1'b0;
      s1Chan   <= '0;
      outValid <= 1'b0;
      outChan  <= '0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
      if (inValid) begin
        s1Chan   <= inChan;
        s1Update <= followMode && updateEn;
      end
      if (s1Valid) outChan <= s1Chan;
    end
  end

  always_comb begin
    strb.capture   = inValid;
    strb.hostWrite = hostWrEn;
    strb.wbWrite   = s1Valid && s1Update;
    strb.outLoad   = s1Valid;
    // a load in the same cycle beats the pending update
    strb.selHost   = hostWrEn && (hostChan == inChan);
    strb.selWb     = !strb.selHost && strb.wbWrite && (s1Chan == inChan);
  end

  assign wbChan = s1Chan;
endmodule

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int SHIFT    = 10,
  parameter int OUT_W    = 11,
  parameter int CH_W     = 7,
  parameter int DEPTH    = 128,
  parameter int SUM_W    = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pf_strobe_t                 strb,
  input  logic [CH_W-1:0]            inChan,
  input  logic [SAMPLE_W-1:0]        inSample,
  input  logic [CH_W-1:0]            hostChan,
  input  logic [SAMPLE_W-1:0]        hostPed,
  input  logic [CH_W-1:0]            wbChan,
  output logic signed [OUT_W-1:0]    outData
);
  logic [SUM_W-1:0]            sumMem [DEPTH];
  logic [SUM_W-1:0]            hostSum;
  logic [SUM_W-1:0]            newSum;
  logic [SUM_W-1:0]            sumRead;
  logic [SUM_W-1:0]            s1Sum;
  logic [SAMPLE_W-1:0]         s1Sample;
  logic [SAMPLE_W-1:0]         ped;
  logic signed [SAMPLE_W:0]    diff;
  logic signed [OUT_W-1:0]     satVal;

  assign hostSum = {hostPed, {SHIFT{1'b0}}};
  assign ped     = s1Sum[SUM_W-1:SHIFT];
  assign diff    = $signed({1'b0, s1Sample}) - $signed({1'b0, ped});
  assign newSum  = s1Sum - {{SHIFT{1'b0}}, ped} + {{SHIFT{1'b0}}, s1Sample};

  always_comb begin
    if (strb.selHost)     sumRead = hostSum;
    else if (strb.selWb)  sumRead = newSum;
    else                  sumRead = sumMem[inChan];
  end

  generate
    if (OUT_W >= SAMPLE_W + 1) begin : g_wide
      assign satVal = OUT_W'(diff);
    end else begin : g_clamp
      localparam logic signed [SAMPLE_W:0] HI_LIM = (SAMPLE_W+1)'((1 << (OUT_W-1)) - 1);
      localparam logic signed [SAMPLE_W:0] LO_LIM = ~HI_LIM;
      always_comb begin
        if (diff > HI_LIM)      satVal = OUT_W'(HI_LIM);
        else if (diff < LO_LIM) satVal = OUT_W'(LO_LIM);
        else                    satVal = OUT_W'(diff);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) sumMem[i] <= '0;
      s1Sum    <= '0;
      s1Sample <= '0;
      outData  <= '0;
    end else begin
      if (strb.wbWrite)   sumMem[wbChan]   <= newSum;
      if (strb.hostWrite) sumMem[hostChan] <= hostSum;
      if (strb.capture) begin
        s1Sum    <= sumRead;
        s1Sample <= inSample;
      end
      if (strb.outLoad) outData <= satVal;
    end
  end
endmodule

// File: rtl/pedestal_follower.sv
module pedestal_follower
  import pf_pkg::*;
#(
  parameter int CHANNELS = 128,
  parameter int SAMPLE_W = 10,
  parameter int SHIFT    = 10,
  parameter int OUT_W    = 11,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int DEPTH   = 1 << CH_W,
  localparam int SUM_W   = SAMPLE_W + SHIFT
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [CH_W-1:0]         inChan,
  input  logic [SAMPLE_W-1:0]     inSample,
  input  logic                    followMode,
  input  logic                    updateEn,
  input  logic                    hostWrEn,
  input  logic [CH_W-1:0]         hostChan,
  input  logic [SAMPLE_W-1:0]     hostPed,
  output logic                    outValid,
  output logic [CH_W-1:0]         outChan,
  output logic signed [OUT_W-1:0] outData
);
  pf_strobe_t      strb;
  logic [CH_W-1:0] wbChan;

  pf_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan),
    .followMode(followMode), .updateEn(updateEn), .hostWrEn(hostWrEn),
    .hostChan(hostChan), .strb(strb), .wbChan(wbChan),
    .outValid(outValid), .outChan(outChan)
  );

  pf_datapath #(
    .SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT), .OUT_W(OUT_W),
    .CH_W(CH_W), .DEPTH(DEPTH), .SUM_W(SUM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inChan(inChan), .inSample(inSample),
    .hostChan(hostChan), .hostPed(hostPed), .wbChan(wbChan), .outData(outData)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int CHANNELS = 128,
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 11,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [CH_W-1:0]         inChan,
  input logic [SAMPLE_W-1:0]     inSample,
  input logic                    outValid,
  input logic [CH_W-1:0]         outChan,
  input logic signed [OUT_W-1:0] outData
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 (outValid && outChan == $past(inChan, 2)));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 $stable(outData));

  // a zero sample can never come out positive, since the baseline is never negative (R3)
  p_zero_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSample == '0) |-> ##2 (outData <= 0));

  // a full-scale sample can never come out negative (R3)
  p_full_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSample == '1) |-> ##2 (outData >= 0));
endmodule

bind pedestal_follower pf_checker #(
  .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan),
  .inSample(inSample), .outValid(outValid), .outChan(outChan), .outData(outData)
);

// File: tb/test_pedestal_follower.sv
module test_pedestal_follower;
  localparam int CHANNELS = 4;
  localparam int SAMPLE_W = 6;
  localparam int SHIFT    = 3;
  localparam int OUT_W    = 6;
  localparam int CH_W     = 2;
  localparam int SMAX     = (1 << SAMPLE_W) - 1;
  localparam int HI       = (1 << (OUT_W-1)) - 1;
  localparam int LO       = -(1 << (OUT_W-1));

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0, followMode = 0, updateEn = 0, hostWrEn = 0;
  logic [CH_W-1:0] inChan = '0, hostChan = '0;
  logic [SAMPLE_W-1:0] inSample = '0, hostPed = '0;
  logic outValid;
  logic [CH_W-1:0] outChan;
  logic signed [OUT_W-1:0] outData;

  always #10 clk = ~clk;

  pedestal_follower #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT), .OUT_W(OUT_W))
    i_pedestal_follower (.*);

  int checks = 0, errors = 0;
  int sums [CHANNELS];
  bit e1v = 0, e2v = 0;
  int e1c, e2c, e1d, e2d;
  string e1t, e2t;

  function automatic int sat(int x);
    if (x > HI) return HI;
    if (x < LO) return LO;
    return x;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int ch, int smp, bit fol, bit en, bit hw, int hch, int hv, string tag);
    int ped, d;
    @(negedge clk);
    if (e2v) begin
      check(outValid == 1'b1, "R2 outValid", int'(outValid), 1);
      check(int'(outChan) == e2c, "R2 outChan", int'(outChan), e2c);
      check(int'(outData) == e2d, e2t, int'(outData), e2d);
    end else begin
      check(outValid == 1'b0, "R2 idle", int'(outValid), 0);
    end
    inValid = v; inChan = CH_W'(ch); inSample = SAMPLE_W'(smp);
    followMode = fol; updateEn = en;
    hostWrEn = hw; hostChan = CH_W'(hch); hostPed = SAMPLE_W'(hv);
    if (hw) sums[hch] = hv << SHIFT;
    d = 0;
    if (v) begin
      ped = sums[ch] >> SHIFT;
      d = sat(smp - ped);
      if (fol && en) sums[ch] = sums[ch] - ped + smp;
    end
    e2v = e1v; e2c = e1c; e2d = e1d; e2t = e1t;
    e1v = v; e1c = ch; e1d = d; e1t = tag;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < CHANNELS; i++) sums[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(outData == 0, "R1 reset outData", int'(outData), 0);
    // R1: zeroed accumulators pass samples unchanged (download mode)
    for (int c = 0; c < CHANNELS; c++) step(1, c, 7 + c, 0, 1, 0, 0, 0, "R1 zero baseline");
    // R3 R4: every baseline against every sample, with clamping
    for (int p = 0; p <= SMAX; p++) begin
      step(0, 0, 0, 0, 1, 1, p % CHANNELS, p, "R8 load");
      for (int s = 0; s <= SMAX; s++) step(1, p % CHANNELS, s, 0, 1, 0, 0, 0, "R3 R4 sweep");
    end
    // R5 R11: follower, channels in rotating order
    for (int i = 0; i < 1500; i++) step(1, i % CHANNELS, $urandom_range(SMAX), 1, 1, 0, 0, 0, "R5 R11 follow");
    // R9: back-to-back on one channel
    for (int i = 0; i < 400; i++) step(1, 2, $urandom_range(SMAX), 1, 1, 0, 0, 0, "R9 back-to-back");
    // R6: frozen, then probe in follower mode
    for (int i = 0; i < 300; i++) step(1, $urandom_range(CHANNELS-1), $urandom_range(SMAX), 1, 0, 0, 0, 0, "R6 frozen");
    for (int i = 0; i < 40; i++) step(1, i % CHANNELS, $urandom_range(SMAX), 1, 1, 0, 0, 0, "R6 probe");
    // R7: download mode leaves accumulators fixed
    for (int i = 0; i < 300; i++) step(1, $urandom_range(CHANNELS-1), $urandom_range(SMAX), 0, 1, 0, 0, 0, "R7 download");
    for (int i = 0; i < 40; i++) step(1, i % CHANNELS, $urandom_range(SMAX), 1, 1, 0, 0, 0, "R7 probe");
    // R2 R8 R10: gaps, loads colliding with samples and pending updates
    for (int i = 0; i < 3000; i++) begin
      int ch = $urandom_range(CHANNELS-1);
      bit hw = ($urandom_range(3) == 0);
      int hc = ($urandom_range(1) == 0) ? ch : $urandom_range(CHANNELS-1);
      step($urandom_range(4) != 0, ch, $urandom_range(SMAX), $urandom_range(5) != 0,
           $urandom_range(5) != 0, hw, hc, $urandom_range(SMAX), "R2 R8 R10 mixed");
    end
    idle(); idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule